// File: doc/BRIEF.md
# Three-Channel Target Timer

This block holds three independent interval timers. Each timer advances on a tick strobe from an external prescaler. It counts those ticks in an 8-bit stage counter against its own 8-bit target. Every time the stage counter reaches the target, the stage counter restarts at zero and a 4-bit completion counter steps by one. Software reads the completion counters through a strobe port. A read returns the count and clears it in the same access, so each read reports the completions since the previous read.

Each timer has its own run bit, loaded by a control write that carries all three bits at once. Loading a 1 into a bit that held 0 restarts that timer. Loading a 1 into a bit that already holds 1 leaves it running undisturbed. A global gate made of a run bit and a halt bit freezes all three timers. The prescaler and the address decode of the register bus stay outside the block: the decoder turns bus accesses into the target-write, control-write and read strobes seen here.

Top module: `ttu_top`

## Requirements
- R1: After reset, all run bits are 0 and every stage and completion counter is 0. Until a timer is started, ticks do not change it, and reading any timer returns 0.
- R2: While timer k runs and the global gate is open, each cycle with tick_i[k]=1 adds one to its stage counter. When the incremented value equals the target, the stage counter becomes 0 and the completion counter of k adds one. With target N, this gives one completion per N ticks.
- R3: A target of 0 means 256 ticks per completion.
- R4: The completion counter wraps from 15 to 0. One cycle raises it by at most one.
- R5: rd_i[k]=1 puts timer k's completion count on rd_data_o[3:0] in the same cycle and clears the count to 0 at the end of that cycle. rd_data_o is the OR of all selected timers and is 0 when rd_i is 0.
- R6: If a read of timer k and a completion of timer k fall in the same cycle, the read returns the old count and the count ends at 1. A tick that does not complete during a read still advances the stage counter.
- R7: A control write whose bit k is 1 while timer k's run bit is 0 clears both of timer k's counters. A tick in that same cycle is not counted.
- R8: A control write whose bit k is 1 while timer k already runs resets nothing.
- R9: Counting happens only while run_en_i=1 and run_halt_i=0. Otherwise both counters hold.
- R10: A control write with bit k equal to 0 stops timer k. Its counters then hold their values, and its completion count can still be read.
- R11: Ticks, target writes and reads of one timer do not change the other timers.
- R12: tgt_we_i[k]=1 loads tgt_data_i into timer k's target. The new target is compared from the next cycle on, and the reset value of every target is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 3 | Per-timer prescaler tick strobes, bit k for timer k |
| tgt_we_i | input | 3 | Per-timer target write strobes |
| tgt_data_i | input | 8 | Target value to load |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_en_i | input | 3 | Run bits carried by the control write, bit k for timer k |
| run_en_i | input | 1 | Global count enable |
| run_halt_i | input | 1 | Global count halt, overrides run_en_i |
| rd_i | input | 3 | Per-timer destructive read strobes |
| rd_data_o | output | 4 | Completion count of the selected timer(s) |

## Verification
A stage counter that is wrong internally never reaches the ports directly. It shows up as a completion landing one or more ticks early or late, so the bench reads just before and just after each expected boundary. For a target of 0, that boundary is 256 ticks out. A restart that did not happen, or one that happened when it should not have, leaves a stale stage count behind. The bench exposes this by reading a few ticks after the control write. A read that fails to clear shows up at the very next read, and an error in the read-versus-completion priority shows up in the read that follows the coinciding cycle.

// File: rtl/ttu_pkg.sv
package ttu_pkg;

    localparam int unsigned TTU_N_CH  = 3;
    localparam int unsigned TTU_TGT_W = 8;
    localparam int unsigned TTU_OUT_W = 4;

    // Per-channel action selected by the enable controller each cycle
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,   // stopped or gated: hold counters
        CH_RESTART = 2'd1,   // run bit rising: clear counters
        CH_STEP    = 2'd2    // running and gate open: ticks advance
    } ch_act_e;

    // Next stage value and whether the target was met
    typedef struct packed {
        logic [TTU_TGT_W-1:0] stage;
        logic                 hit;
    } stage_step_t;

    // Advance the stage counter by one tick and compare with the target.
    // An 8-bit increment wraps to 0, so target 0 is met after 256 ticks.
    function automatic stage_step_t f_stage_step(
        input logic [TTU_TGT_W-1:0] stage,
        input logic [TTU_TGT_W-1:0] target
    );
        stage_step_t          r;
        logic [TTU_TGT_W-1:0] inc;
        inc     = stage + TTU_TGT_W'(1);
        r.hit   = (inc == target);
        r.stage = r.hit ? '0 : inc;
        return r;
    endfunction

endpackage

// File: rtl/ttu_enable_ctl.sv
module ttu_enable_ctl
    import ttu_pkg::*;
#(
    parameter int unsigned N_CH = TTU_N_CH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ctl_we_i,
    input  logic [N_CH-1:0]          ctl_en_i,
    input  logic                     run_en_i,
    input  logic                     run_halt_i,
    output logic [N_CH-1:0]          en_q_o,
    output ch_act_e [N_CH-1:0]       act_o
);

    logic [N_CH-1:0] en_q;
    logic            gate_open;

    assign gate_open = run_en_i && !run_halt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (ctl_we_i) begin
            en_q <= ctl_en_i;
        end
    end

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_act
            always_comb begin
                if (ctl_we_i && ctl_en_i[k] && !en_q[k]) begin
                    act_o[k] = CH_RESTART;
                end else if (en_q[k] && gate_open) begin
                    act_o[k] = CH_STEP;
                end else begin
                    act_o[k] = CH_IDLE;
                end
            end
        end
    endgenerate

    assign en_q_o = en_q;

endmodule

// File: rtl/ttu_channel.sv
module ttu_channel
    import ttu_pkg::*;
#(
    parameter int unsigned TGT_W = TTU_TGT_W,
    parameter int unsigned OUT_W = TTU_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_act_e          act_i,
    input  logic             tick_i,
    input  logic             tgt_we_i,
    input  logic [TGT_W-1:0] tgt_data_i,
    input  logic             rd_i,
    output logic [TGT_W-1:0] stage_o,
    output logic [OUT_W-1:0] outc_o,
    output logic             hit_o
);

    logic [TGT_W-1:0] target_q;
    logic [TGT_W-1:0] stage_q;
    logic [OUT_W-1:0] outc_q;
    stage_step_t      nxt;
    logic             step;
    logic [OUT_W-1:0] outc_base;

    assign step      = (act_i == CH_STEP) && tick_i;
    assign nxt       = f_stage_step(stage_q, target_q);
    assign hit_o     = step && nxt.hit;
    assign outc_base = rd_i ? '0 : outc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
        end else if (tgt_we_i) begin
            target_q <= tgt_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            outc_q  <= '0;
        end else if (act_i == CH_RESTART) begin
            stage_q <= '0;
            outc_q  <= '0;
        end else begin
            if (step) begin
                stage_q <= nxt.stage;
            end
            outc_q <= outc_base + OUT_W'(hit_o);
        end
    end

    assign stage_o = stage_q;
    assign outc_o  = outc_q;

endmodule

// File: rtl/ttu_rd_mux.sv
module ttu_rd_mux #(
    parameter int unsigned N_CH  = 3,
    parameter int unsigned OUT_W = 4
) (
    input  logic [N_CH-1:0]            rd_i,
    input  logic [N_CH-1:0][OUT_W-1:0] outc_i,
    output logic [OUT_W-1:0]           data_o
);

    always_comb begin
        data_o = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (rd_i[k]) begin
                data_o = data_o | outc_i[k];
            end
        end
    end

endmodule

// File: rtl/ttu_top.sv
module ttu_top
    import ttu_pkg::*;
#(
    parameter int unsigned N_CH  = TTU_N_CH,
    parameter int unsigned TGT_W = TTU_TGT_W,
    parameter int unsigned OUT_W = TTU_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  tick_i,
    input  logic [N_CH-1:0]  tgt_we_i,
    input  logic [TGT_W-1:0] tgt_data_i,
    input  logic             ctl_we_i,
    input  logic [N_CH-1:0]  ctl_en_i,
    input  logic             run_en_i,
    input  logic             run_halt_i,
    input  logic [N_CH-1:0]  rd_i,
    output logic [OUT_W-1:0] rd_data_o
);

    logic [N_CH-1:0]            en_q;
    ch_act_e [N_CH-1:0]         act;
    logic [N_CH-1:0][TGT_W-1:0] stage_all;
    logic [N_CH-1:0][OUT_W-1:0] out_all;
    logic [N_CH-1:0]            hit_all;

    ttu_enable_ctl #(.N_CH(N_CH)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ctl_we_i   (ctl_we_i),
        .ctl_en_i   (ctl_en_i),
        .run_en_i   (run_en_i),
        .run_halt_i (run_halt_i),
        .en_q_o     (en_q),
        .act_o      (act)
    );

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_ch
            ttu_channel #(.TGT_W(TGT_W), .OUT_W(OUT_W)) u_ch (
                .clk        (clk),
                .rst        (rst),
                .act_i      (act[k]),
                .tick_i     (tick_i[k]),
                .tgt_we_i   (tgt_we_i[k]),
                .tgt_data_i (tgt_data_i),
                .rd_i       (rd_i[k]),
                .stage_o    (stage_all[k]),
                .outc_o     (out_all[k]),
                .hit_o      (hit_all[k])
            );
        end
    endgenerate

    ttu_rd_mux #(.N_CH(N_CH), .OUT_W(OUT_W)) u_rd (
        .rd_i   (rd_i),
        .outc_i (out_all),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/ttu_chk.sv
module ttu_chk #(
    parameter int unsigned N_CH  = 3,
    parameter int unsigned TGT_W = 8,
    parameter int unsigned OUT_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_CH-1:0]          tick_i,
    input logic                     ctl_we_i,
    input logic [N_CH-1:0]          ctl_en_i,
    input logic                     run_en_i,
    input logic                     run_halt_i,
    input logic [N_CH-1:0]          rd_i,
    input logic [N_CH-1:0]          en_q,
    input logic [N_CH-1:0][TGT_W-1:0] stage_all,
    input logic [N_CH-1:0][OUT_W-1:0] out_all
);

    logic gate;
    assign gate = run_en_i && !run_halt_i;

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_chk
            // R7: rising run bit clears both counters
            a_r7_rise_clears: assert property (@(posedge clk) disable iff (rst)
                (ctl_we_i && ctl_en_i[k] && !en_q[k]) |=>
                    (stage_all[k] == '0 && out_all[k] == '0));

            // R8: rewriting a set run bit disturbs nothing
            a_r8_reenable_keeps: assert property (@(posedge clk) disable iff (rst)
                (ctl_we_i && ctl_en_i[k] && en_q[k] && !rd_i[k] && !(gate && tick_i[k])) |=>
                    ($stable(stage_all[k]) && $stable(out_all[k])));

            // R9: closed gate holds both counters
            a_r9_gate_hold: assert property (@(posedge clk) disable iff (rst)
                (!gate && !ctl_we_i && !rd_i[k]) |=>
                    ($stable(stage_all[k]) && $stable(out_all[k])));

            // R5: a read leaves at most the one completion of that cycle
            a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
                (rd_i[k]) |=> (out_all[k] <= OUT_W'(1)));

            // R4: without read or control write, count steps by at most one
            a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
                (!rd_i[k] && !ctl_we_i) |=>
                    (out_all[k] == $past(out_all[k]) ||
                     out_all[k] == $past(out_all[k]) + OUT_W'(1)));
        end
    endgenerate

endmodule

bind ttu_top ttu_chk #(.N_CH(N_CH), .TGT_W(TGT_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_en_i   (ctl_en_i),
    .run_en_i   (run_en_i),
    .run_halt_i (run_halt_i),
    .rd_i       (rd_i),
    .en_q       (en_q),
    .stage_all  (stage_all),
    .out_all    (out_all)
);

// File: tb/sim_ttu_top.sv
module sim_ttu_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] tick_i;
    logic [2:0] tgt_we_i;
    logic [7:0] tgt_data_i;
    logic       ctl_we_i;
    logic [2:0] ctl_en_i;
    logic       run_en_i;
    logic       run_halt_i;
    logic [2:0] rd_i;
    logic [3:0] rd_data_o;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ttu_top u0 (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .tgt_we_i   (tgt_we_i),
        .tgt_data_i (tgt_data_i),
        .ctl_we_i   (ctl_we_i),
        .ctl_en_i   (ctl_en_i),
        .run_en_i   (run_en_i),
        .run_halt_i (run_halt_i),
        .rd_i       (rd_i),
        .rd_data_o  (rd_data_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of strobes; starts and ends at a falling edge
    task automatic cyc(input logic [2:0] tk, input logic [2:0] rd,
                       input logic cw, input logic [2:0] ce,
                       output logic [3:0] d);
        tick_i   = tk;
        rd_i     = rd;
        ctl_we_i = cw;
        ctl_en_i = ce;
        #1 d = rd_data_o;
        @(negedge clk);
        tick_i   = '0;
        rd_i     = '0;
        ctl_we_i = 1'b0;
        ctl_en_i = '0;
    endtask

    task automatic ticks(input logic [2:0] m, input int n);
        logic [3:0] d;
        for (int i = 0; i < n; i++) cyc(m, 3'b000, 1'b0, 3'b000, d);
    endtask

    task automatic rd(input int k, output logic [3:0] d);
        cyc(3'b000, 3'(1 << k), 1'b0, 3'b000, d);
    endtask

    task automatic ctl(input logic [2:0] ce);
        logic [3:0] d;
        cyc(3'b000, 3'b000, 1'b1, ce, d);
    endtask

    task automatic tgt(input int k, input logic [7:0] v);
        tgt_we_i   = 3'(1 << k);
        tgt_data_i = v;
        @(negedge clk);
        tgt_we_i   = '0;
    endtask

    // Stop all, then start all: every counter restarts at 0
    task automatic fresh();
        ctl(3'b000);
        ctl(3'b111);
    endtask

    task automatic t_reset();
        logic [3:0] d;
        ticks(3'b111, 3);
        for (int k = 0; k < 3; k++) begin
            rd(k, d);
            check("R1 idle after reset", d, 0);
        end
    endtask

    task automatic t_basic();
        logic [3:0] d;
        fresh();
        tgt(0, 8'd3);
        ticks(3'b001, 8);
        rd(0, d); check("R2 8 ticks target 3", d, 2);
        rd(0, d); check("R5 second read cleared", d, 0);
        ticks(3'b001, 1);
        rd(0, d); check("R2 ninth tick completes", d, 1);
        tgt(0, 8'd2);
        ticks(3'b001, 4);
        rd(0, d); check("R12 new target 2", d, 2);
        d = 4'hF;
        cyc(3'b000, 3'b000, 1'b0, 3'b000, d);
        check("R5 no read gives 0", d, 0);
    endtask

    task automatic t_target0();
        logic [3:0] d;
        fresh();
        tgt(1, 8'd0);
        ticks(3'b010, 255);
        rd(1, d); check("R3 255 ticks target 0", d, 0);
        ticks(3'b010, 1);
        rd(1, d); check("R3 256th tick completes", d, 1);
    endtask

    task automatic t_wrap();
        logic [3:0] d;
        fresh();
        tgt(2, 8'd1);
        ticks(3'b100, 15);
        rd(2, d); check("R4 max count 15", d, 15);
        ticks(3'b100, 17);
        rd(2, d); check("R4 wraps 17 to 1", d, 1);
    endtask

    task automatic t_coincide();
        logic [3:0] d;
        fresh();
        tgt(2, 8'd1);
        ticks(3'b100, 3);
        cyc(3'b100, 3'b100, 1'b0, 3'b000, d);
        check("R6 read returns old", d, 3);
        rd(2, d); check("R6 ends at 1", d, 1);
        tgt(0, 8'd3);
        ticks(3'b001, 4);
        cyc(3'b001, 3'b001, 1'b0, 3'b000, d);
        check("R6 read with plain tick", d, 1);
        ticks(3'b001, 1);
        rd(0, d); check("R6 stage advanced during read", d, 1);
    endtask

    task automatic t_enable();
        logic [3:0] d;
        fresh();
        tgt(0, 8'd3);
        ticks(3'b001, 2);
        ctl(3'b111);
        ticks(3'b001, 1);
        rd(0, d); check("R8 rewrite of set bit", d, 1);
        ticks(3'b001, 5);
        ctl(3'b110);
        rd(0, d); check("R10 held after stop", d, 1);
        ticks(3'b001, 3);
        rd(0, d); check("R10 no count while stopped", d, 0);
        cyc(3'b001, 3'b000, 1'b1, 3'b111, d);
        ticks(3'b001, 2);
        rd(0, d); check("R7 stage cleared, tick ignored", d, 0);
        ticks(3'b001, 1);
        rd(0, d); check("R7 completes after 3", d, 1);
        ticks(3'b001, 3);
        ctl(3'b110);
        ctl(3'b111);
        rd(0, d); check("R7 count cleared on start", d, 0);
    endtask

    task automatic t_gate();
        logic [3:0] d;
        fresh();
        tgt(0, 8'd1);
        run_halt_i = 1'b1;
        ticks(3'b001, 3);
        rd(0, d); check("R9 halt blocks", d, 0);
        run_halt_i = 1'b0;
        run_en_i   = 1'b0;
        ticks(3'b001, 3);
        rd(0, d); check("R9 run_en low blocks", d, 0);
        run_en_i = 1'b1;
        ticks(3'b001, 1);
        rd(0, d); check("R9 gate open counts", d, 1);
    endtask

    task automatic t_indep();
        logic [3:0] d;
        fresh();
        tgt(0, 8'd1);
        tgt(1, 8'd1);
        tgt(2, 8'd1);
        ticks(3'b010, 2);
        rd(0, d); check("R11 timer0 untouched", d, 0);
        rd(1, d); check("R11 timer1 counted", d, 2);
        rd(2, d); check("R11 timer2 untouched", d, 0);
    endtask

    initial begin
        rst        = 1'b1;
        tick_i     = '0;
        tgt_we_i   = '0;
        tgt_data_i = '0;
        ctl_we_i   = 1'b0;
        ctl_en_i   = '0;
        run_en_i   = 1'b1;
        run_halt_i = 1'b0;
        rd_i       = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_target0();
        t_wrap();
        t_coincide();
        t_enable();
        t_gate();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

endmodule